// File: doc/BRIEF.md
# Shared-Exponent Block Encoder and Interleaved Packer

This block takes 64 single-precision floating-point values per transfer and turns them into a block-floating-point image. The values are split into eight blocks of eight. Each block keeps one 8-bit exponent for all its members, and each member is reduced to a sign bit and a 7-bit magnitude. The exponent field is as wide as the single-precision exponent, so the block format keeps the full dynamic range.

The shared exponent of a block is the largest biased exponent among its members. Each member's significand, implicit one included, is shifted right by how far its own exponent falls short of that maximum. It is then rounded to nearest-even into seven bits. The eight exponents and the 64 entries are written into one 576-bit word that repeats a 9-byte pattern: one exponent byte, then the eight entry bytes of that block.

Transfers use a valid/ready handshake on both sides. A three-register pipeline accepts one group per cycle while the consumer is ready, and the whole pipeline halts while the output is held.

Top module: `bfp_pack_enc`

## Requirements
- R1: The shared exponent of block k (input values 8k..8k+7) equals the maximum of the biased exponent fields (bits 30:23) of those eight values.
- R2: For an input with biased exponent e > 0 in a block with shared exponent E, the entry magnitude is the 24-bit significand {1, fraction} divided by 2^(17+E-e) and rounded. The entry byte is {sign, magnitude[6:0]}, with the sign in bit 7.
- R3: Rounding is to nearest. An exact half rounds to the even magnitude.
- R4: A rounding carry that would give magnitude 128 saturates to 127. The sign bit is kept.
- R5: An input with biased exponent 0 (zero or denormal) gets magnitude 0 and keeps its sign bit. A block whose eight inputs all have exponent 0 gets shared exponent 0.
- R6: Inputs far below the block maximum lose all magnitude. With E-e = 7, a significand of exactly 2^23 is a tie and rounds to 0, while any nonzero fraction rounds to 1. With E-e >= 8 the magnitude is 0.
- R7: Input value i sits in data_i[32i+31:32i]. Output byte b sits in data_o[8b+7:8b]. Byte 9k holds the shared exponent of block k, and byte 9k+1+j holds the entry of input 8k+j.
- R8: A group accepted at rising edge n (valid_i and ready_o high) appears on data_o with valid_o high after rising edge n+2, provided ready_i was high in between.
- R9: ready_o is high whenever valid_o is low or ready_i is high. While valid_o is high and ready_i is low, valid_o stays high and data_o stays stable. Groups leave in the order they arrived, and back-to-back groups flow at one per cycle.
- R10: While rst_ni is low, valid_o is low, data_o is zero and ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input group valid |
| ready_o | output | 1 | Encoder can accept a group |
| data_i | input | 2048 | 64 single-precision values, value i in bits 32i+31:32i |
| valid_o | output | 1 | Packed word valid |
| ready_i | input | 1 | Consumer accepts the packed word |
| data_o | output | 576 | Interleaved packed block image |

## Verification
The encoder is tried with several kinds of block. Blocks whose members all share one exponent check the plain significand truncation. Blocks with mixed exponents separate the choice of the maximum from the per-entry shift. Fractions placed just below, exactly at and just above the half point tell round-to-nearest-even apart from truncation and from round-half-up. An all-ones significand at the maximum exponent exposes a carry that would wrap instead of saturating. Zeros, negative zero and denormals show whether the implicit one is wrongly forced and whether signs are lost. Each block gets a distinct exponent so that any exponent byte or entry byte placed in the wrong slot shows up. Random groups streamed under a periodic stall on ready_i check latency, ordering and that the held word does not change.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  parameter int unsigned FP_W      = 32;
  parameter int unsigned FP_EXP_W  = 8;
  parameter int unsigned FP_FRAC_W = 23;
  parameter int unsigned FP_SIG_W  = FP_FRAC_W + 1;
endpackage

// File: rtl/bfp_max_exp.sv
module bfp_max_exp #(
  parameter int unsigned N  = 8,
  parameter int unsigned EW = 8
) (
  input  logic [N*EW-1:0] exps_i,
  output logic [EW-1:0]   max_o
);
  always_comb begin
    max_o = '0;
    for (int i = 0; i < N; i++) begin
      if (exps_i[i*EW +: EW] > max_o) max_o = exps_i[i*EW +: EW];
    end
  end
endmodule

// File: rtl/bfp_entry_quant.sv
module bfp_entry_quant
  import bfp_pkg::*;
#(
  parameter int unsigned MAN_W = 7
) (
  input  logic [FP_W-1:0]     val_i,
  input  logic [FP_EXP_W-1:0] shared_exp_i,
  output logic [MAN_W:0]      entry_o
);
  localparam int unsigned BASE_SH = FP_SIG_W - MAN_W;
  localparam int unsigned MAX_SH  = FP_SIG_W + 1;     // beyond this everything is sticky
  localparam int unsigned WIDE_W  = FP_SIG_W + MAX_SH;
  localparam int unsigned SH_W    = FP_EXP_W + 1;
  localparam logic [SH_W-1:0]     DIFF_CAP = SH_W'(MAX_SH - BASE_SH);
  localparam logic [FP_SIG_W-1:0] MAX_MAG  = FP_SIG_W'((1 << MAN_W) - 1);

  logic                 sign;
  logic [FP_EXP_W-1:0]  exp_v;
  logic [FP_SIG_W-1:0]  sig;
  logic [SH_W-1:0]      diff, sh;
  logic [WIDE_W-1:0]    wide;
  logic [FP_SIG_W-1:0]  keep, rnd;
  logic                 guard, sticky, rnd_up;
  logic [MAN_W-1:0]     mag;

  assign sign  = val_i[FP_W-1];
  assign exp_v = val_i[FP_W-2 -: FP_EXP_W];
  assign sig   = {1'b1, val_i[FP_FRAC_W-1:0]};

  always_comb begin
    diff = {1'b0, shared_exp_i} - {1'b0, exp_v};
    if (diff > DIFF_CAP) sh = SH_W'(MAX_SH);
    else                 sh = SH_W'(BASE_SH) + diff;
    wide   = {sig, {MAX_SH{1'b0}}} >> sh;
    keep   = wide[WIDE_W-1 -: FP_SIG_W];
    guard  = wide[MAX_SH-1];
    sticky = |wide[MAX_SH-2:0];
    rnd_up = guard & (sticky | keep[0]);
    rnd    = keep + FP_SIG_W'(rnd_up);
    if (exp_v == '0)       mag = '0;
    else if (rnd > MAX_MAG) mag = '1;
    else                   mag = rnd[MAN_W-1:0];
  end

  assign entry_o = {sign, mag};
endmodule

// File: rtl/bfp_interleave.sv
module bfp_interleave #(
  parameter int unsigned NB    = 8,
  parameter int unsigned BS    = 8,
  parameter int unsigned EW    = 8,
  parameter int unsigned ENT_W = 8
) (
  input  logic [NB*EW-1:0]              exps_i,
  input  logic [NB*BS*ENT_W-1:0]        ents_i,
  output logic [NB*(EW+BS*ENT_W)-1:0]   word_o
);
  localparam int unsigned CH_W = EW + BS*ENT_W;

  for (genvar k = 0; k < NB; k++) begin : g_blk
    assign word_o[k*CH_W +: EW] = exps_i[k*EW +: EW];
    for (genvar j = 0; j < BS; j++) begin : g_ent
      assign word_o[k*CH_W + EW + j*ENT_W +: ENT_W] = ents_i[(k*BS + j)*ENT_W +: ENT_W];
    end
  end
endmodule

// File: rtl/bfp_pack_enc.sv
module bfp_pack_enc
  import bfp_pkg::*;
#(
  parameter int unsigned N_BLK  = 8,
  parameter int unsigned BLK_SZ = 8,
  parameter int unsigned MAN_W  = 7
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic                                          valid_i,
  output logic                                          ready_o,
  input  logic [N_BLK*BLK_SZ*FP_W-1:0]                  data_i,
  output logic                                          valid_o,
  input  logic                                          ready_i,
  output logic [N_BLK*(FP_EXP_W+BLK_SZ*(MAN_W+1))-1:0]  data_o
);
  localparam int unsigned N_VAL = N_BLK * BLK_SZ;
  localparam int unsigned ENT_W = MAN_W + 1;
  localparam int unsigned IN_W  = N_VAL * FP_W;
  localparam int unsigned OUT_W = N_BLK * (FP_EXP_W + BLK_SZ*ENT_W);

  logic adv;
  logic s1_v, s2_v;
  logic [IN_W-1:0] s1_d;
  logic [N_BLK-1:0][FP_EXP_W-1:0] max_c, s2_exp;
  logic [N_VAL-1:0][ENT_W-1:0]    ent_c, s2_ent;
  logic [OUT_W-1:0]               word_c;

  // single enable stalls every stage while the output is held
  assign adv     = !valid_o || ready_i;
  assign ready_o = adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0;
      s1_d <= '0;
    end else if (adv) begin
      s1_v <= valid_i;
      s1_d <= data_i;
    end
  end

  for (genvar k = 0; k < N_BLK; k++) begin : g_blk
    logic [BLK_SZ*FP_EXP_W-1:0] blk_exps;
    for (genvar j = 0; j < BLK_SZ; j++) begin : g_fld
      assign blk_exps[j*FP_EXP_W +: FP_EXP_W] = s1_d[(k*BLK_SZ+j)*FP_W + FP_FRAC_W +: FP_EXP_W];
      bfp_entry_quant #(.MAN_W(MAN_W)) u_quant (
        .val_i        (s1_d[(k*BLK_SZ+j)*FP_W +: FP_W]),
        .shared_exp_i (max_c[k]),
        .entry_o      (ent_c[k*BLK_SZ+j])
      );
    end
    bfp_max_exp #(.N(BLK_SZ), .EW(FP_EXP_W)) u_max (
      .exps_i (blk_exps),
      .max_o  (max_c[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v   <= 1'b0;
      s2_exp <= '0;
      s2_ent <= '0;
    end else if (adv) begin
      s2_v   <= s1_v;
      s2_exp <= max_c;
      s2_ent <= ent_c;
    end
  end

  bfp_interleave #(.NB(N_BLK), .BS(BLK_SZ), .EW(FP_EXP_W), .ENT_W(ENT_W)) u_pack (
    .exps_i (s2_exp),
    .ents_i (s2_ent),
    .word_o (word_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (adv) begin
      valid_o <= s2_v;
      data_o  <= word_c;
    end
  end

  AST_HOLD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o) else $error("held word dropped"); // R9
  AST_HOLD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> $stable(data_o)) else $error("held word changed"); // R9

  for (genvar k = 0; k < N_BLK; k++) begin : g_chk
    logic [BLK_SZ-1:0] lead_bits, mag_nz;
    for (genvar j = 0; j < BLK_SZ; j++) begin : g_bit
      assign lead_bits[j] = s2_ent[k*BLK_SZ+j][MAN_W-1];
      assign mag_nz[j]    = |s2_ent[k*BLK_SZ+j][MAN_W-1:0];
    end
    AST_ZERO_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s2_v && s2_exp[k] == '0) |-> (mag_nz == '0)) else $error("zero block has magnitude"); // R5
    AST_LEAD_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s2_v && s2_exp[k] != '0) |-> (|lead_bits)) else $error("no entry carries the maximum"); // R1
  end
endmodule

// File: tb/tb_bfp_pack_enc.sv
module tb_bfp_pack_enc;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic ready_i = 1'b1;
  logic ready_o, valid_o;
  logic [2047:0] data_i = '0;
  logic [575:0]  data_o;

  int checks = 0;
  int errors = 0;
  logic [2047:0] grp_q [8];

  bfp_pack_enc dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
    .data_i(data_i), .valid_o(valid_o), .ready_i(ready_i), .data_o(data_o)
  );

  always #10 clk_i = ~clk_i;

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [31:0] mk(input bit s, input int e, input int f);
    return {s, 8'(e), 23'(f)};
  endfunction

  function automatic logic [7:0] enc_one(input logic [31:0] x, input int emax);
    int e;
    longint sig, keep, rem, half;
    int sh;
    e = int'(x[30:23]);
    if (e == 0) return {x[31], 7'd0};
    sh = 17 + emax - e;
    if (sh > 40) return {x[31], 7'd0};
    sig  = longint'({1'b1, x[22:0]});
    keep = sig >> sh;
    rem  = sig - (keep << sh);
    half = longint'(1) << (sh - 1);
    if (rem > half || (rem == half && keep % 2 == 1)) keep++;
    if (keep > 127) keep = 127;
    return {x[31], 7'(keep)};
  endfunction

  function automatic logic [575:0] model(input logic [2047:0] g);
    logic [575:0] w;
    w = '0;
    for (int k = 0; k < 8; k++) begin
      int emax;
      emax = 0;
      for (int j = 0; j < 8; j++)
        if (int'(g[32*(8*k+j)+23 +: 8]) > emax) emax = int'(g[32*(8*k+j)+23 +: 8]);
      w[72*k +: 8] = 8'(emax);
      for (int j = 0; j < 8; j++)
        w[72*k + 8 + 8*j +: 8] = enc_one(g[32*(8*k+j) +: 32], emax);
    end
    return w;
  endfunction

  task automatic check_word(input logic [575:0] act, input logic [575:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s word act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic check_byte(input logic [575:0] w, input int b, input logic [7:0] exp, input string tag);
    checks++;
    if (w[8*b +: 8] !== exp) begin
      errors++;
      $display("FAIL %s byte %0d act=%h exp=%h", tag, b, w[8*b +: 8], exp);
    end
  endtask

  // drives n groups from grp_q, stalling ready_i every stall-th cycle; called at a negedge
  task automatic run_stream(input int n, input int stall, input string tag);
    int in_idx, out_idx, cyc;
    logic [575:0] prev;
    logic prev_hold, in_fire, out_fire;
    in_idx = 0; out_idx = 0; cyc = 0; prev = '0; prev_hold = 1'b0;
    while (out_idx < n && cyc < 400) begin
      ready_i = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
      valid_i = (in_idx < n);
      data_i  = (in_idx < n) ? grp_q[in_idx] : '0;
      #1;
      if (prev_hold) begin
        check_bit(valid_o, 1'b1, "R9 hold valid");
        check_word(data_o, prev, "R9 hold data");
      end
      in_fire  = valid_i && ready_o;
      out_fire = valid_o && ready_i;
      if (out_fire) begin
        check_word(data_o, model(grp_q[out_idx]), tag);
        out_idx++;
      end
      prev_hold = valid_o && !ready_i;
      prev = data_o;
      if (in_fire) in_idx++;
      @(posedge clk_i);
      @(negedge clk_i);
      cyc++;
    end
    valid_i = 1'b0;
    ready_i = 1'b1;
    checks++;
    if (out_idx != n) begin
      errors++;
      $display("FAIL %s words act=%0d exp=%0d", tag, out_idx, n);
    end
  endtask

  task automatic t_reset();
    #1;
    check_bit(valid_o, 1'b0, "R10 valid_o in reset");
    check_word(data_o, '0, "R10 data_o in reset");
    check_bit(ready_o, 1'b1, "R10 ready_o in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    ready_i = 1'b0;
    #1;
    check_bit(ready_o, 1'b1, "R9 ready_o with empty output");
    ready_i = 1'b1;
  endtask

  task automatic t_latency();
    logic [2047:0] g;
    for (int i = 0; i < 64; i++) g[32*i +: 32] = mk(i[0], 127, i << 16);
    valid_i = 1'b1; data_i = g;
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
    check_bit(valid_o, 1'b0, "R8 not after edge n");
    @(posedge clk_i);
    @(negedge clk_i);
    check_bit(valid_o, 1'b0, "R8 not after edge n+1");
    @(posedge clk_i);
    @(negedge clk_i);
    check_bit(valid_o, 1'b1, "R8 valid after edge n+2");
    check_word(data_o, model(g), "R8 data");
    check_byte(data_o, 0, 8'd127, "R1 exponent of 1.x block");
    check_byte(data_o, 1, 8'h40, "R2 1.0 encodes 64");
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_same_exp();
    for (int i = 0; i < 64; i++) grp_q[0][32*i +: 32] = mk(1'b0, 130, (i * 65536) % 8388608);
    for (int i = 0; i < 64; i++) grp_q[1][32*i +: 32] = mk(i[1], 130, 23'h400000);
    run_stream(2, 0, "R2 same exponent");
  endtask

  task automatic t_mixed();
    logic [575:0] w;
    for (int i = 0; i < 64; i++) grp_q[0][32*i +: 32] = mk(1'b0, 120 + (i % 5), 23'h200000);
    run_stream(1, 0, "R1 mixed exponents");
    // direct: max 127 (1.0) with 0.5 and 0.25 -> 64, 32, 16
    for (int i = 0; i < 64; i++) grp_q[0][32*i +: 32] = mk(1'b0, 127 - (i % 3), 0);
    valid_i = 1'b1; data_i = grp_q[0];
    @(posedge clk_i); @(negedge clk_i); valid_i = 1'b0;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    w = data_o;
    check_byte(w, 0, 8'd127, "R1 max exponent");
    check_byte(w, 1, 8'h40, "R2 d=0");
    check_byte(w, 2, 8'h20, "R2 d=1");
    check_byte(w, 3, 8'h10, "R2 d=2");
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic t_round();
    logic [575:0] w;
    grp_q[0] = '0;
    for (int i = 0; i < 64; i++) grp_q[0][32*i +: 32] = mk(1'b0, 130, 0);
    grp_q[0][32*0 +: 32] = mk(1'b0, 130, (0 << 17) | (1 << 16));     // 64.5 -> 64
    grp_q[0][32*1 +: 32] = mk(1'b0, 130, (1 << 17) | (1 << 16));     // 65.5 -> 66
    grp_q[0][32*2 +: 32] = mk(1'b0, 130, (2 << 17) | (1 << 16) | 1); // above half -> 67
    grp_q[0][32*3 +: 32] = mk(1'b1, 130, (3 << 17) | 16'hFFFF);      // below half -> 67
    valid_i = 1'b1; data_i = grp_q[0];
    @(posedge clk_i); @(negedge clk_i); valid_i = 1'b0;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    w = data_o;
    check_byte(w, 1, 8'h40, "R3 tie even stays");
    check_byte(w, 2, 8'h42, "R3 tie odd rounds up");
    check_byte(w, 3, 8'h43, "R3 above half");
    check_byte(w, 4, 8'hC3, "R3 below half negative");
    check_word(w, model(grp_q[0]), "R3 round block");
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic t_saturate();
    logic [575:0] w;
    for (int i = 0; i < 64; i++) grp_q[0][32*i +: 32] = mk(i[0], 140, 23'h7FFFFF);
    valid_i = 1'b1; data_i = grp_q[0];
    @(posedge clk_i); @(negedge clk_i); valid_i = 1'b0;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    w = data_o;
    check_byte(w, 1, 8'h7F, "R4 positive saturation");
    check_byte(w, 2, 8'hFF, "R4 negative saturation");
    check_byte(w, 0, 8'd140, "R4 exponent not bumped");
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic t_zero();
    logic [575:0] w;
    grp_q[0] = '0;
    grp_q[0][32*1 +: 32] = mk(1'b1, 0, 0);          // -0 in block 0
    grp_q[0][32*2 +: 32] = mk(1'b0, 0, 23'h123456); // denormal in block 0
    grp_q[0][32*8 +: 32] = mk(1'b0, 127, 0);        // block 1 has 1.0
    grp_q[0][32*9 +: 32] = mk(1'b1, 0, 23'h7FFFFF); // negative denormal
    valid_i = 1'b1; data_i = grp_q[0];
    @(posedge clk_i); @(negedge clk_i); valid_i = 1'b0;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    w = data_o;
    check_byte(w, 0, 8'h00, "R5 zero block exponent");
    check_byte(w, 2, 8'h80, "R5 negative zero");
    check_byte(w, 3, 8'h00, "R5 denormal");
    check_byte(w, 9, 8'd127, "R5 block with normal");
    check_byte(w, 11, 8'h80, "R5 negative denormal beside normal");
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic t_far();
    logic [575:0] w;
    for (int i = 0; i < 64; i++) grp_q[0][32*i +: 32] = mk(1'b0, 100, 0);
    grp_q[0][32*0 +: 32] = mk(1'b0, 137, 0);
    grp_q[0][32*1 +: 32] = mk(1'b0, 130, 0); // exact tie -> 0
    grp_q[0][32*2 +: 32] = mk(1'b0, 130, 1); // above tie -> 1
    grp_q[0][32*3 +: 32] = mk(1'b1, 129, 23'h7FFFFF); // d=8 -> 0
    valid_i = 1'b1; data_i = grp_q[0];
    @(posedge clk_i); @(negedge clk_i); valid_i = 1'b0;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    w = data_o;
    check_byte(w, 2, 8'h00, "R6 d=7 tie");
    check_byte(w, 3, 8'h01, "R6 d=7 above tie");
    check_byte(w, 4, 8'h80, "R6 d=8");
    check_byte(w, 5, 8'h00, "R6 d=37");
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic t_layout();
    logic [575:0] w;
    for (int i = 0; i < 64; i++) grp_q[0][32*i +: 32] = mk(1'b0, 120 + i / 8, (i % 8) << 17);
    valid_i = 1'b1; data_i = grp_q[0];
    @(posedge clk_i); @(negedge clk_i); valid_i = 1'b0;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    w = data_o;
    for (int k = 0; k < 8; k++) begin
      check_byte(w, 9*k, 8'(120 + k), "R7 exponent byte");
      check_byte(w, 9*k + 1 + (k % 8), 8'(64 + (k % 8)), "R7 entry byte");
    end
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic t_stream();
    for (int g = 0; g < 6; g++)
      for (int i = 0; i < 64; i++)
        grp_q[g][32*i +: 32] = mk(1'($urandom), 100 + int'($urandom % 20), int'($urandom % 8388608));
    run_stream(6, 0, "R8 back-to-back");
    for (int g = 0; g < 6; g++)
      for (int i = 0; i < 64; i++)
        grp_q[g][32*i +: 32] = mk(1'($urandom), 1 + int'($urandom % 254), int'($urandom % 8388608));
    run_stream(6, 3, "R9 stalled stream");
  endtask

  initial begin
    t_reset();
    t_latency();
    t_same_exp();
    t_mixed();
    t_round();
    t_saturate();
    t_zero();
    t_far();
    t_layout();
    t_stream();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule